// File: doc/BRIEF.md
# Calorimeter Energy-Sum Trigger

This block forms a first-level trigger decision from two calorimeter groups, a barrel group and a forward group. Each group delivers one unsigned 12-bit digitized amplitude per channel per clock. The block adds each group's channels into a group total every cycle. It weights the forward total by four with a two-bit shift and compares the weighted energy and the raw totals against programmable thresholds. Pedestals and calibration are assumed to be removed upstream.

Four discriminator inputs qualify the decision: a start-counter hit, a gas Cherenkov bit, a timing-chamber hit and a scintillator hit. Each single-cycle discriminator pulse is stretched into a window of 9 cycles. This approximates a 35 ns coincidence at a 4 ns sample period. Three trigger equations are evaluated in parallel and reported as a 4-bit condition pattern:
- a physics term: weighted energy with a start hit;
- an electron term, which can be met in two ways;
- a reduced-rate coincidence term.

A 2-bit mode input selects which equation drives the registered trigger bit. The latency is the same in every mode.

Top module: `calo_sum_trigger`

## Requirements
- R1: While `rst_n` is low at a clock edge, `trig` and `hit_pattern` are 0 after that edge. All group totals and discriminator windows are cleared, so no hit seen before reset can qualify a decision after reset.
- R2: Each group total is the exact unsigned sum of its 16 channels, with no wrap even when every channel is 4095. The weighted energy (barrel + 4 × forward, up to 327600) fits in the 19-bit physics threshold range.
- R3: `hit_pattern[0]` (physics term) is 1 when barrel + 4 × forward > `cfg_phys_thr` and the start-counter window is open.
- R4: `hit_pattern[1]` (electron barrel term) is 1 when the barrel total > `cfg_large_thr`. No discriminator is needed for this term.
- R5: `hit_pattern[2]` (electron forward term) is 1 when the forward total > `cfg_fwd_thr` and the Cherenkov window is open.
- R6: `hit_pattern[3]` (coincidence term) is 1 when the forward total > `cfg_low_thr` and both the chamber window and the scintillator window are open in the same cycle.
- R7: A discriminator pulse sampled at clock edge k opens its window for the decisions made at edges k+1 through k+9 (9 cycles). A new pulse restarts the window.
- R8: `trig` follows `cfg_mode`:
  - 0: `hit_pattern[0]`
  - 1: `hit_pattern[1] | hit_pattern[2]`
  - 2: `hit_pattern[3]`
  - 3: OR of all four bits
- R9: Samples applied before clock edge k affect `trig` and `hit_pattern` only after edge k+1. The latency is 2 edges in every mode.
- R10: A change to a threshold or to `cfg_mode` applied before edge k takes effect in the outputs after edge k.
- R11: All comparisons are strict. A sum equal to its threshold does not meet the term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bar_samples | input | 192 | 16 barrel amplitudes, channel i at bits [12i+11:12i] |
| fwd_samples | input | 192 | 16 forward amplitudes, channel i at bits [12i+11:12i] |
| start_hit | input | 1 | Start-counter discriminator |
| cherenkov_hit | input | 1 | Gas Cherenkov discriminator |
| chamber_hit | input | 1 | Timing-chamber discriminator |
| scint_hit | input | 1 | Scintillator discriminator |
| cfg_mode | input | 2 | Trigger equation select (see R8) |
| cfg_phys_thr | input | 19 | Weighted-energy threshold |
| cfg_large_thr | input | 16 | Barrel total threshold for the electron term |
| cfg_fwd_thr | input | 16 | Forward total threshold for the electron term |
| cfg_low_thr | input | 16 | Forward total threshold for the coincidence term |
| trig | output | 1 | Registered trigger decision |
| hit_pattern | output | 4 | Registered condition bits (see R3 to R6) |

## Verification
Samples and discriminator pulses reach the outputs two edges after they are applied. A threshold or mode change reaches them one edge after it is applied. A discriminator pulse keeps its term qualified for the nine decisions that follow its first one.

The driver applies each step's inputs on a falling edge and predicts the outputs from the requirements. To do this it keeps the previous step's totals and the step index of each discriminator's last pulse. It then queues the prediction tagged with the rising edge at which it is due. The monitor samples shortly after each rising edge and compares only the entries due at that edge, so every check lands on the exact cycle the requirements fix.

// File: rtl/calo_trig_pkg.sv
`timescale 1ns/1ps
// Shared types for the calorimeter energy-sum trigger.
// Assumes: mode encodings are fixed by the configuration interface.
package calo_trig_pkg;
    typedef enum logic [1:0] {
        MODE_PHYS  = 2'd0,
        MODE_ELEC  = 2'd1,
        MODE_COINC = 2'd2,
        MODE_ANY   = 2'd3
    } trig_mode_e;

    // Condition pattern bit positions
    localparam int PAT_PHYS  = 0;
    localparam int PAT_ELEC_B = 1;
    localparam int PAT_ELEC_F = 2;
    localparam int PAT_COINC = 3;
    localparam int PAT_W     = 4;

    // Discriminator window positions
    localparam int WIN_START = 0;
    localparam int WIN_CHER  = 1;
    localparam int WIN_CHAM  = 2;
    localparam int WIN_SCIN  = 3;
    localparam int N_DISC    = 4;
endpackage

// File: rtl/calo_group_sum.sv
`timescale 1ns/1ps
// Adds all channel amplitudes of one calorimeter group each clock and
// registers the total. Assumes unsigned, pedestal-free samples; SUM_W is
// wide enough to hold N_CH full-scale samples.
module calo_group_sum #(
    parameter int N_CH     = 16,
    parameter int SAMPLE_W = 12,
    parameter int SUM_W    = SAMPLE_W + $clog2(N_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH*SAMPLE_W-1:0] samples_i,
    output logic [SUM_W-1:0]         sum_o
);
    localparam int MAX_SUM = N_CH * ((1 << SAMPLE_W) - 1);

    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] sum_q;

    // Combinational total of every channel in the group
    always_comb begin
        acc = '0;
        for (int i = 0; i < N_CH; i++) begin
            acc = acc + SUM_W'(samples_i[i*SAMPLE_W +: SAMPLE_W]);
        end
    end

    // Register the total; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= acc;
    end

    assign sum_o = sum_q;

    // R2: the registered total never exceeds the full-scale sum (no wrap)
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q <= SUM_W'(MAX_SUM));
endmodule

// File: rtl/disc_stretcher.sv
`timescale 1ns/1ps
// Stretches a single-cycle discriminator pulse into a WIN-cycle window.
// A new pulse reloads the window. Assumes the pulse is synchronous to clk.
module disc_stretcher #(
    parameter int WIN = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(WIN + 1);

    logic [CNT_W-1:0] cnt;

    // Load on a hit, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (hit_i)          cnt <= CNT_W'(WIN);
        else if (cnt != '0)      cnt <= cnt - CNT_W'(1);
    end

    assign active_o = (cnt != '0);

    // R7: a hit opens the window at the next edge
    p_hit_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> active_o);
    // R7: the window counter stays within its length
    p_win_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WIN));
endmodule

// File: rtl/trig_decision.sv
`timescale 1ns/1ps
// Evaluates the physics, electron and coincidence terms from registered
// group totals and discriminator windows, selects one by mode, and
// registers trigger and pattern. Thresholds and mode are sampled directly,
// so a change applies at the next edge.
module trig_decision
    import calo_trig_pkg::*;
#(
    parameter int SUM_W  = 16,
    parameter int WSUM_W = SUM_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SUM_W-1:0]  bar_sum_i,
    input  logic [SUM_W-1:0]  fwd_sum_i,
    input  logic [N_DISC-1:0] win_i,
    input  logic [1:0]        mode_i,
    input  logic [WSUM_W-1:0] phys_thr_i,
    input  logic [SUM_W-1:0]  large_thr_i,
    input  logic [SUM_W-1:0]  fwd_thr_i,
    input  logic [SUM_W-1:0]  low_thr_i,
    output logic              trig_o,
    output logic [PAT_W-1:0]  pattern_o
);
    logic [WSUM_W-1:0] weighted;
    logic [PAT_W-1:0]  pat_d;
    logic              trig_d;
    logic [PAT_W-1:0]  pat_q;
    logic              trig_q;

    // Weighted energy: barrel plus forward shifted left by two
    always_comb begin
        weighted = {3'b000, bar_sum_i} + {1'b0, fwd_sum_i, 2'b00};
    end

    // Evaluate every trigger term in parallel
    always_comb begin
        pat_d[PAT_PHYS]   = (weighted > phys_thr_i) && win_i[WIN_START];
        pat_d[PAT_ELEC_B] = (bar_sum_i > large_thr_i);
        pat_d[PAT_ELEC_F] = (fwd_sum_i > fwd_thr_i) && win_i[WIN_CHER];
        pat_d[PAT_COINC]  = (fwd_sum_i > low_thr_i) && win_i[WIN_CHAM]
                            && win_i[WIN_SCIN];
    end

    // Pick the trigger equation named by the mode
    always_comb begin
        case (trig_mode_e'(mode_i))
            MODE_PHYS:  trig_d = pat_d[PAT_PHYS];
            MODE_ELEC:  trig_d = pat_d[PAT_ELEC_B] | pat_d[PAT_ELEC_F];
            MODE_COINC: trig_d = pat_d[PAT_COINC];
            default:    trig_d = |pat_d;
        endcase
    end

    // Register decision outputs; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q  <= '0;
            trig_q <= 1'b0;
        end else begin
            pat_q  <= pat_d;
            trig_q <= trig_d;
        end
    end

    assign trig_o    = trig_q;
    assign pattern_o = pat_q;

    // R1: reset clears the outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (trig_o == 1'b0 && pattern_o == '0));
    // R3: the physics term needs an open start window
    p_phys_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_o[PAT_PHYS] |-> $past(win_i[WIN_START]));
    // R8: a trigger is always backed by some condition
    p_trig_backed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (pattern_o != '0));
    // R8: physics mode follows the physics term
    p_phys_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == 2'd0) |-> (trig_o == pattern_o[PAT_PHYS]));
endmodule

// File: rtl/calo_sum_trigger.sv
`timescale 1ns/1ps
// Calorimeter energy-sum trigger top. Sums two calorimeter groups, stretches
// four discriminator inputs into coincidence windows, and forms a registered
// trigger plus a condition pattern. Fixed latency of two edges from samples
// to outputs. Assumes pedestal-subtracted, unsigned samples.
module calo_sum_trigger
    import calo_trig_pkg::*;
#(
    parameter int N_CH     = 16,
    parameter int SAMPLE_W = 12,
    parameter int WIN      = 9,
    parameter int SUM_W    = SAMPLE_W + $clog2(N_CH),
    parameter int WSUM_W   = SUM_W + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH*SAMPLE_W-1:0] bar_samples,
    input  logic [N_CH*SAMPLE_W-1:0] fwd_samples,
    input  logic                     start_hit,
    input  logic                     cherenkov_hit,
    input  logic                     chamber_hit,
    input  logic                     scint_hit,
    input  logic [1:0]               cfg_mode,
    input  logic [WSUM_W-1:0]        cfg_phys_thr,
    input  logic [SUM_W-1:0]         cfg_large_thr,
    input  logic [SUM_W-1:0]         cfg_fwd_thr,
    input  logic [SUM_W-1:0]         cfg_low_thr,
    output logic                     trig,
    output logic [PAT_W-1:0]         hit_pattern
);
    logic [SUM_W-1:0]  bar_sum;
    logic [SUM_W-1:0]  fwd_sum;
    logic [N_DISC-1:0] disc_raw;
    logic [N_DISC-1:0] disc_win;

    assign disc_raw = {scint_hit, chamber_hit, cherenkov_hit, start_hit};

    calo_group_sum #(.N_CH(N_CH), .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_bar_sum (
        .clk(clk), .rst_n(rst_n), .samples_i(bar_samples), .sum_o(bar_sum));

    calo_group_sum #(.N_CH(N_CH), .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_fwd_sum (
        .clk(clk), .rst_n(rst_n), .samples_i(fwd_samples), .sum_o(fwd_sum));

    // One window stretcher per discriminator input
    for (genvar g = 0; g < N_DISC; g++) begin : g_disc
        disc_stretcher #(.WIN(WIN)) u_stretch (
            .clk(clk), .rst_n(rst_n), .hit_i(disc_raw[g]), .active_o(disc_win[g]));
    end

    trig_decision #(.SUM_W(SUM_W), .WSUM_W(WSUM_W)) u_decide (
        .clk(clk), .rst_n(rst_n),
        .bar_sum_i(bar_sum), .fwd_sum_i(fwd_sum), .win_i(disc_win),
        .mode_i(cfg_mode), .phys_thr_i(cfg_phys_thr),
        .large_thr_i(cfg_large_thr), .fwd_thr_i(cfg_fwd_thr),
        .low_thr_i(cfg_low_thr),
        .trig_o(trig), .pattern_o(hit_pattern));
endmodule

// File: tb/calo_sum_trigger_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts outputs from the requirements and
// queues them by due edge; the monitor compares shortly after each edge.
module calo_sum_trigger_bench;
    localparam int N_CH = 16;
    localparam int SW   = 12;
    localparam int WIN  = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_CH*SW-1:0] bar_samples = '0;
    logic [N_CH*SW-1:0] fwd_samples = '0;
    logic              start_hit = 1'b0, cherenkov_hit = 1'b0;
    logic              chamber_hit = 1'b0, scint_hit = 1'b0;
    logic [1:0]        cfg_mode = 2'd0;
    logic [18:0]       cfg_phys_thr = '0;
    logic [15:0]       cfg_large_thr = '0, cfg_fwd_thr = '0, cfg_low_thr = '0;
    logic              trig;
    logic [3:0]        hit_pattern;

    calo_sum_trigger u_calo_sum_trigger (
        .clk(clk), .rst_n(rst_n), .bar_samples(bar_samples), .fwd_samples(fwd_samples),
        .start_hit(start_hit), .cherenkov_hit(cherenkov_hit),
        .chamber_hit(chamber_hit), .scint_hit(scint_hit),
        .cfg_mode(cfg_mode), .cfg_phys_thr(cfg_phys_thr),
        .cfg_large_thr(cfg_large_thr), .cfg_fwd_thr(cfg_fwd_thr),
        .cfg_low_thr(cfg_low_thr), .trig(trig), .hit_pattern(hit_pattern));

    always #2.5 clk = ~clk;

    typedef struct {
        int         due;
        logic [3:0] pat;
        logic       trg;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   edges = 0;
    bit   done = 1'b0;

    // staged stimulus, copied to the ports at the next falling edge
    int s_bb = 0, s_bi = 0, s_fb = 0, s_fi = 0;
    int s_mode = 0, s_phys = 0, s_large = 0, s_fwd = 0, s_low = 0;
    // model state
    int prev_b = 0, prev_f = 0;
    int last_h[4] = '{-1000, -1000, -1000, -1000};

    function automatic bit win_open(int d, int n);
        return (n - 1 - last_h[d] >= 0) && (n - 1 - last_h[d] < WIN);
    endfunction

    // Apply one step and queue the prediction due at this step's edge
    task automatic step(input logic [3:0] hits, input string tag);
        int cur_b, cur_f, n;
        logic [3:0] p;
        logic t;
        @(negedge clk);
        n = edges;
        cur_b = 0; cur_f = 0;
        for (int i = 0; i < N_CH; i++) begin
            bar_samples[i*SW +: SW] = SW'(s_bb + i*s_bi);
            fwd_samples[i*SW +: SW] = SW'(s_fb + i*s_fi);
            cur_b += int'(bar_samples[i*SW +: SW]);
            cur_f += int'(fwd_samples[i*SW +: SW]);
        end
        {scint_hit, chamber_hit, cherenkov_hit, start_hit} = hits;
        cfg_mode = 2'(s_mode); cfg_phys_thr = 19'(s_phys);
        cfg_large_thr = 16'(s_large); cfg_fwd_thr = 16'(s_fwd); cfg_low_thr = 16'(s_low);
        p[0] = (prev_b + 4*prev_f > s_phys) && win_open(0, n);
        p[1] = (prev_b > s_large);
        p[2] = (prev_f > s_fwd) && win_open(1, n);
        p[3] = (prev_f > s_low) && win_open(2, n) && win_open(3, n);
        case (s_mode)
            0: t = p[0];
            1: t = p[1] | p[2];
            2: t = p[3];
            default: t = |p;
        endcase
        exp_q.push_back('{due: n, pat: p, trg: t, tag: tag});
        prev_b = cur_b; prev_f = cur_f;
        for (int d = 0; d < 4; d++) if (hits[d]) last_h[d] = n;
    endtask

    // Synchronous reset with port and model clearing; checks R1 directly
    task automatic do_reset(input int cyc);
        @(negedge clk);
        rst_n = 1'b0;
        bar_samples = '0; fwd_samples = '0;
        {scint_hit, chamber_hit, cherenkov_hit, start_hit} = 4'b0;
        s_bb = 0; s_bi = 0; s_fb = 0; s_fi = 0;
        for (int c = 0; c < cyc; c++) @(negedge clk);
        checks++;
        if (trig !== 1'b0 || hit_pattern !== 4'b0) begin
            errors++;
            $display("FAIL R1 reset: trig=%b pattern=%b expected trig=0 pattern=0000",
                     trig, hit_pattern);
        end
        prev_b = 0; prev_f = 0;
        for (int d = 0; d < 4; d++) last_h[d] = -1000;
        rst_n = 1'b1;
    endtask

    // Monitor: compare predictions due at each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (exp_q.size() > 0 && exp_q[0].due == edges) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (trig !== e.trg || hit_pattern !== e.pat) begin
                    errors++;
                    $display("FAIL %s: edge %0d trig=%b pattern=%b expected trig=%b pattern=%b",
                             e.tag, edges, trig, hit_pattern, e.trg, e.pat);
                end
            end
            edges++;
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(3);                                     // R1 at start
        s_phys = 1000; s_large = 3000; s_fwd = 500; s_low = 200; s_mode = 0;

        // R3 + R7: weighted 160 + 4*960 = 4000, one start pulse, 11 quiet steps
        s_bb = 10; s_fb = 60;
        step(4'b0001, "R3");
        for (int k = 0; k < 11; k++) step(4'b0000, "R7");

        // R11: equal threshold fails, one below passes
        s_phys = 4000; step(4'b0001, "R11");
        step(4'b0000, "R11");
        s_phys = 3999; step(4'b0000, "R11");
        step(4'b0000, "R11");
        for (int k = 0; k < 9; k++) step(4'b0000, "R7");

        // R4: barrel 16*200 + 3*120 = 3560 > 3000, no discriminator
        s_mode = 1; s_bb = 200; s_bi = 3; s_fb = 0;
        step(4'b0000, "R4"); step(4'b0000, "R4");
        s_bb = 180; s_bi = 0;                            // 2880: below
        step(4'b0000, "R4"); step(4'b0000, "R4");
        // R11 on barrel: exactly 3000 is not enough
        s_large = 3000; s_bb = 187; s_bi = 0;            // 2992
        step(4'b0000, "R11");
        s_bb = 0; s_bi = 25;                             // 25*120 = 3000
        step(4'b0000, "R11"); step(4'b0000, "R11");

        // R5: forward 640 > 500 needs the Cherenkov window
        s_bi = 0; s_bb = 0; s_fb = 40;
        step(4'b0000, "R5"); step(4'b0000, "R5");
        step(4'b0010, "R5");
        for (int k = 0; k < 10; k++) step(4'b0000, "R5");

        // R6: coincidence, forward 320 > 200, chamber then scint 3 steps later
        s_mode = 2; s_fb = 20;
        step(4'b0100, "R6");
        step(4'b0000, "R6"); step(4'b0000, "R6");
        step(4'b1000, "R6");
        for (int k = 0; k < 12; k++) step(4'b0000, "R6");

        // R8: mode 3 ORs everything; mode 0 ignores electron terms
        s_mode = 3; s_bb = 250;                          // barrel 4000 > 3000
        step(4'b0000, "R8"); step(4'b0000, "R8");
        s_mode = 0; step(4'b0000, "R8"); step(4'b0000, "R8");
        s_mode = 1; step(4'b0000, "R8");

        // R10: threshold and mode changes act at the next edge
        s_large = 5000; step(4'b0000, "R10");
        s_large = 3000; step(4'b0000, "R10");
        s_mode = 2; step(4'b0000, "R10");
        s_mode = 1; step(4'b0000, "R10");

        // R2: full-scale samples, weighted 65520 + 4*65520 = 327600
        s_mode = 0; s_bb = 4095; s_fb = 4095; s_phys = 327599; s_large = 65535;
        step(4'b0001, "R2"); step(4'b0000, "R2");
        s_phys = 327600; step(4'b0000, "R2"); step(4'b0000, "R2");

        // R9: one-step sample pulse appears exactly two edges later
        s_mode = 1; s_large = 3000; s_bb = 0; s_fb = 0;
        step(4'b0000, "R9"); step(4'b0000, "R9");
        s_bb = 250; step(4'b0000, "R9");
        s_bb = 0;  step(4'b0000, "R9"); step(4'b0000, "R9"); step(4'b0000, "R9");

        // R1: a coincidence window opened before reset does not survive it
        s_mode = 2; s_fb = 20;
        step(4'b1100, "R1");
        do_reset(2);
        s_fb = 20;
        for (int k = 0; k < 6; k++) step(4'b0000, "R1");

        step(4'b0000, "flush"); step(4'b0000, "flush");
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule